// File: doc/BRIEF.md
# Bus Master Address Arbitration Unit

This block lives inside a bus master attached to a bus whose address and data phases are split. It decides, cycle by cycle, whether the grant line seen from the central arbiter may be acted upon, raises and drops the request line, and opens the master's own address tenure by driving a one-cycle transfer-start pulse and holding the address-busy line until the address acknowledge arrives. The central arbiter, the data phase and the snoop logic sit outside the block.

A grant is only usable when no address tenure is open on the bus and the retry line has been quiet for two consecutive cycles. A master that is parked, meaning it already holds the grant, may start at once without ever raising its request. The request line is forced low for a cycle after the master accepts a grant and for a cycle after a retry, unless the retry was raised by this master to push a cache block. A local counter limits how many address tenures may wait on data completion.

All three bus outputs are registered. A condition sampled at a rising edge shows on the outputs right after that edge.

Top module: `arb_addr_unit`

## Requirements
- R1: A grant is qualified in a cycle only if `bus_gnt_i` is 1, `bus_busy_i` is 0, this master's own tenure is not open, and `bus_retry_i` is 0 both in this cycle and in the previous cycle. A transfer starts only on a qualified grant.
- R2: A tenure started by another master, marked by `bus_ts_i` high, counts as open from the cycle after that pulse until `bus_aack_i` is sampled. While it is open, no grant is qualified.
- R3: If `bus_retry_i` is 1 and `snoop_push_i` is 0 at an edge, `bus_req_o` is 0 after that edge. If `snoop_push_i` is 1, the retry does not force the request low.
- R4: After the edge at which a transfer starts, `bus_req_o` is 0 for that cycle, even when a new request arrives in the same cycle.
- R5: A transfer start drives `bus_ts_o` high for exactly one cycle. `bus_busy_o` goes high in that same cycle and stays high until the edge at which `bus_aack_i` is sampled. After that edge it is 0.
- R6: The count of outstanding tenures rises by one on each transfer start. It falls by one on each `data_done_i` while it is nonzero. No transfer starts while the count equals `PIPE_MAX`.
- R7: A pulse on `xact_req_i` at the same edge as a qualified grant starts the transfer at once: `bus_ts_o` is 1 after that edge, and `bus_req_o` stays 0 throughout.
- R8: `cancel_i` discards the pending transaction. `bus_req_o` is 0 after that edge, and no transfer starts for the discarded transaction.
- R9: While a transaction is pending and no transfer starts, `bus_req_o` is 1 from the next edge on. This also holds while the outstanding count is at `PIPE_MAX`.
- R10: While `rst` is high, `bus_req_o`, `bus_ts_o` and `bus_busy_o` are 0. The retry history, the open-tenure flags, the pending flag and the outstanding count are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| xact_req_i | input | 1 | One-cycle strobe: a bus transaction is now pending |
| cancel_i | input | 1 | Strobe that drops the pending transaction |
| snoop_push_i | input | 1 | This master raised the retry to push a cache block |
| data_done_i | input | 1 | Data completion of one outstanding tenure |
| bus_gnt_i | input | 1 | Grant from the central arbiter |
| bus_busy_i | input | 1 | Address-busy line driven by other masters |
| bus_ts_i | input | 1 | Transfer-start pulse from other masters |
| bus_aack_i | input | 1 | Address acknowledge |
| bus_retry_i | input | 1 | Address retry |
| bus_req_o | output | 1 | Request for the address bus |
| bus_busy_o | output | 1 | Address-busy driven by this master |
| bus_ts_o | output | 1 | Transfer-start pulse of this master |

## Verification
Two functions can land in the same edge, and the bench provokes both pairs. In the first, a transaction strobe arrives together with a qualified grant, so the start and the request sequencing compete. The bench judges this by requiring the start pulse with no request ever raised. In the second, a retry falls one cycle before a grant, so the retry history and the grant qualification meet. The bench shows that the grant is refused and that the next grant is taken. Random traffic also mixes cancels, retries with and without the push flag, and completions at the pipeline limit. It compares every output, every cycle, against a bench model built from the requirements.

// File: rtl/arb_addr_pkg.sv
package arb_addr_pkg;

    // Snapshot of the bus lines sampled by the qualification logic.
    typedef struct packed {
        logic gnt;
        logic busy;
        logic ts;
        logic aack;
        logic retry;
    } bus_obs_t;

    // Tenure state of this master.
    typedef enum logic [1:0] {
        TEN_IDLE  = 2'd0,
        TEN_START = 2'd1,
        TEN_WAIT  = 2'd2
    } tenure_st_e;

    // A retry forces the request off unless this master pushed a block.
    function automatic logic retry_forces_off(input logic retry, input logic push);
        return retry & ~push;
    endfunction

    // Next value of a saturating up/down occupancy counter.
    function automatic int unsigned occ_next(input int unsigned cur,
                                             input logic inc,
                                             input logic dec);
        int unsigned v;
        v = cur;
        if (inc) v = v + 1;
        if (dec && cur != 0) v = v - 1;
        return v;
    endfunction

endpackage

// File: rtl/arb_qualify.sv
module arb_qualify
    import arb_addr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_obs_t obs,
    input  logic     own_open,
    output logic     qual,
    output logic     retry_hist
);

    logic retry_q;
    logic other_open_q;

    // Retry history over one cycle.
    always_ff @(posedge clk) begin
        if (rst) retry_q <= 1'b0;
        else     retry_q <= obs.retry;
    end

    // Tenure of another master, open from its start pulse to acknowledge.
    always_ff @(posedge clk) begin
        if (rst)           other_open_q <= 1'b0;
        else if (obs.ts)   other_open_q <= 1'b1;
        else if (obs.aack) other_open_q <= 1'b0;
    end

    logic addr_busy;
    always_comb begin
        addr_busy = obs.busy | own_open | other_open_q;
        qual      = obs.gnt & ~addr_busy & ~obs.retry & ~retry_q;
    end

    assign retry_hist = retry_q;

endmodule

// File: rtl/arb_req_seq.sv
module arb_req_seq
    import arb_addr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic xact_req_i,
    input  logic cancel_i,
    input  logic qual,
    input  logic room,
    input  logic retry_i,
    input  logic push_i,
    output logic start,
    output logic br_q
);

    logic pend_q;
    logic pend_any;
    logic pend_d;
    logic br_d;

    always_comb begin
        pend_any = (pend_q | xact_req_i) & ~cancel_i;
        start    = qual & pend_any & room;
        pend_d   = pend_any & ~start;
        br_d     = pend_d & ~start & ~retry_forces_off(retry_i, push_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            br_q   <= 1'b0;
        end else begin
            pend_q <= pend_d;
            br_q   <= br_d;
        end
    end

endmodule

// File: rtl/arb_tenure.sv
module arb_tenure
    import arb_addr_pkg::*;
#(
    parameter int PIPE_MAX = 2,
    localparam int CW = $clog2(PIPE_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          aack_i,
    input  logic          done_i,
    output logic          ts_o,
    output logic          busy_o,
    output logic [CW-1:0] cnt_o,
    output logic          room
);

    tenure_st_e    st_q;
    tenure_st_e    st_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TEN_IDLE:  if (start) st_d = TEN_START;
            TEN_START: st_d = aack_i ? TEN_IDLE : TEN_WAIT;
            TEN_WAIT:  if (aack_i) st_d = TEN_IDLE;
            default:   st_d = TEN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= TEN_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= CW'(occ_next(int'(cnt_q), start, done_i));
        end
    end

    assign ts_o   = (st_q == TEN_START);
    assign busy_o = (st_q != TEN_IDLE);
    assign cnt_o  = cnt_q;
    assign room   = (int'(cnt_q) < PIPE_MAX);

endmodule

// File: rtl/arb_addr_unit.sv
module arb_addr_unit
    import arb_addr_pkg::*;
#(
    parameter int PIPE_MAX = 2,
    localparam int CW = $clog2(PIPE_MAX + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic xact_req_i,
    input  logic cancel_i,
    input  logic snoop_push_i,
    input  logic data_done_i,
    input  logic bus_gnt_i,
    input  logic bus_busy_i,
    input  logic bus_ts_i,
    input  logic bus_aack_i,
    input  logic bus_retry_i,
    output logic bus_req_o,
    output logic bus_busy_o,
    output logic bus_ts_o
);

    bus_obs_t      obs;
    logic          qual;
    logic          retry_hist;
    logic          start;
    logic          room;
    logic [CW-1:0] pipe_cnt;

    assign obs = '{gnt: bus_gnt_i, busy: bus_busy_i, ts: bus_ts_i,
                   aack: bus_aack_i, retry: bus_retry_i};

    arb_qualify u_qual (
        .clk        (clk),
        .rst        (rst),
        .obs        (obs),
        .own_open   (bus_busy_o),
        .qual       (qual),
        .retry_hist (retry_hist)
    );

    arb_req_seq u_req (
        .clk        (clk),
        .rst        (rst),
        .xact_req_i (xact_req_i),
        .cancel_i   (cancel_i),
        .qual       (qual),
        .room       (room),
        .retry_i    (bus_retry_i),
        .push_i     (snoop_push_i),
        .start      (start),
        .br_q       (bus_req_o)
    );

    arb_tenure #(.PIPE_MAX(PIPE_MAX)) u_ten (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .aack_i (bus_aack_i),
        .done_i (data_done_i),
        .ts_o   (bus_ts_o),
        .busy_o (bus_busy_o),
        .cnt_o  (pipe_cnt),
        .room   (room)
    );

endmodule

// File: rtl/arb_addr_unit_chk.sv
module arb_addr_unit_chk #(
    parameter int PIPE_MAX = 2,
    localparam int CW = $clog2(PIPE_MAX + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          snoop_push_i,
    input logic          bus_gnt_i,
    input logic          bus_busy_i,
    input logic          bus_aack_i,
    input logic          bus_retry_i,
    input logic          bus_req_o,
    input logic          bus_busy_o,
    input logic          bus_ts_o,
    input logic [CW-1:0] cnt
);

    AST_NO_START_NO_GNT: assert property (@(posedge clk) disable iff (rst)
        !bus_gnt_i |=> !bus_ts_o);                                   // R1
    AST_NO_START_RETRY: assert property (@(posedge clk) disable iff (rst)
        bus_retry_i |=> !bus_ts_o);                                  // R1
    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        bus_busy_i |=> !bus_ts_o);                                   // R1
    AST_REQ_OFF_RETRY: assert property (@(posedge clk) disable iff (rst)
        (bus_retry_i && !snoop_push_i) |=> !bus_req_o);              // R3
    AST_REQ_OFF_START: assert property (@(posedge clk) disable iff (rst)
        bus_ts_o |-> !bus_req_o);                                    // R4
    AST_TS_SINGLE: assert property (@(posedge clk) disable iff (rst)
        bus_ts_o |=> !bus_ts_o);                                     // R5
    AST_BUSY_WITH_TS: assert property (@(posedge clk) disable iff (rst)
        bus_ts_o |-> bus_busy_o);                                    // R5
    AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (bus_busy_o && bus_aack_i) |=> !bus_busy_o);                 // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) <= PIPE_MAX);                                      // R6
    AST_FULL_NO_START: assert property (@(posedge clk) disable iff (rst)
        (int'(cnt) == PIPE_MAX) |=> !bus_ts_o);                      // R6
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!bus_req_o && !bus_ts_o && !bus_busy_o));           // R10

endmodule

bind arb_addr_unit arb_addr_unit_chk #(.PIPE_MAX(PIPE_MAX)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .snoop_push_i (snoop_push_i),
    .bus_gnt_i    (bus_gnt_i),
    .bus_busy_i   (bus_busy_i),
    .bus_aack_i   (bus_aack_i),
    .bus_retry_i  (bus_retry_i),
    .bus_req_o    (bus_req_o),
    .bus_busy_o   (bus_busy_o),
    .bus_ts_o     (bus_ts_o),
    .cnt          (pipe_cnt)
);

// File: tb/tb_arb_addr_unit.sv
module tb_arb_addr_unit;

    localparam int CLK_PERIOD = 10;
    localparam int PMAX = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req, cancel, push, done, gnt, busy_i, ts_i, aack, retry;
    logic br, busy_o, ts_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    arb_addr_unit #(.PIPE_MAX(PMAX)) dut (
        .clk(clk), .rst(rst), .xact_req_i(req), .cancel_i(cancel),
        .snoop_push_i(push), .data_done_i(done), .bus_gnt_i(gnt),
        .bus_busy_i(busy_i), .bus_ts_i(ts_i), .bus_aack_i(aack),
        .bus_retry_i(retry), .bus_req_o(br), .bus_busy_o(busy_o),
        .bus_ts_o(ts_o)
    );

    // Bench model state, written from the requirements.
    logic m_rq, m_other, m_own, m_ts, m_br, m_pend;
    int   m_cnt;

    function automatic logic exp_qual();
        return gnt && !busy_i && !m_own && !m_other && !retry && !m_rq;
    endfunction

    task automatic model_step();
        logic pany, st;
        if (rst) begin
            m_rq = 0; m_other = 0; m_own = 0; m_ts = 0; m_br = 0;
            m_pend = 0; m_cnt = 0;
            return;
        end
        pany = (m_pend || req) && !cancel;
        st   = exp_qual() && pany && (m_cnt < PMAX);
        m_rq = retry;
        if (ts_i) m_other = 1; else if (aack) m_other = 0;
        if (st) m_own = 1; else if (m_own && aack) m_own = 0;
        m_ts   = st;
        if (st) m_cnt++;
        if (done && m_cnt > (st ? 1 : 0)) m_cnt--;
        else if (done && !st && m_cnt != 0) m_cnt--;
        m_pend = pany && !st;
        m_br   = m_pend && !(retry && !push);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cycle %0d actual=%b expected=%b", tag, cyc, act, exp);
        end
    endtask

    task automatic idle();
        req = 0; cancel = 0; push = 0; done = 0; gnt = 0;
        busy_i = 0; ts_i = 0; aack = 0; retry = 0;
    endtask

    // One clock: model follows the edge, outputs are read at the falling edge.
    task automatic tick();
        @(posedge clk);
        model_step();
        cyc++;
        @(negedge clk);
    endtask

    task automatic model_cmp(input string tag);
        chk({tag, " req"},  br,     m_br);
        chk({tag, " ts"},   ts_o,   m_ts);
        chk({tag, " busy"}, busy_o, m_own);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        idle();
        rst = 1;
        @(negedge clk);
        tick(); tick();
        chk("R10 reset req", br, 0);
        chk("R10 reset ts", ts_o, 0);
        chk("R10 reset busy", busy_o, 0);
        rst = 0;

        // R7: parked start, request and qualified grant together.
        req = 1; gnt = 1; tick();
        chk("R7 parked ts", ts_o, 1);
        chk("R7 parked req", br, 0);
        chk("R5 busy with ts", busy_o, 1);
        idle(); tick();
        chk("R5 ts one cycle", ts_o, 0);
        chk("R5 busy held", busy_o, 1);
        chk("R7 req stays low", br, 0);
        aack = 1; tick();
        chk("R5 busy released", busy_o, 0);
        idle(); done = 1; tick(); idle();

        // R1: retry one cycle before a grant.
        req = 1; retry = 1; tick();
        chk("R3 req off after retry", br, 0);
        idle(); gnt = 1; tick();
        chk("R1 retry history blocks grant", ts_o, 0);
        chk("R9 req raised while pending", br, 1);
        gnt = 1; req = 1; tick();
        chk("R1 later grant taken", ts_o, 1);
        chk("R4 req low after start", br, 0);
        idle(); aack = 1; tick(); idle(); done = 1; tick(); idle();

        // R8: cancel while request is high.
        req = 1; tick();
        chk("R9 req high", br, 1);
        idle(); cancel = 1; tick();
        chk("R8 req dropped", br, 0);
        idle(); gnt = 1; tick();
        chk("R8 no start after cancel", ts_o, 0);
        idle();

        // R1: busy line blocks the grant.
        req = 1; gnt = 1; busy_i = 1; tick();
        chk("R1 busy blocks", ts_o, 0);
        idle(); gnt = 1; tick();
        chk("R1 start once free", ts_o, 1);
        idle(); aack = 1; tick(); idle();

        // R2: another master's tenure blocks until acknowledge.
        ts_i = 1; tick();
        idle(); req = 1; gnt = 1; tick();
        chk("R2 open tenure blocks", ts_o, 0);
        idle(); aack = 1; tick();
        idle(); gnt = 1; tick();
        chk("R2 start after ack", ts_o, 1);
        idle(); aack = 1; tick(); idle();

        // R6: outstanding count is at the limit (two starts, no completion).
        req = 1; gnt = 1; tick();
        chk("R6 full blocks start", ts_o, 0);
        chk("R9 req at limit", br, 1);
        idle(); gnt = 1; done = 1; tick();
        chk("R6 no start same edge as done", ts_o, 0);
        idle(); gnt = 1; tick();
        chk("R6 start after done", ts_o, 1);
        idle(); aack = 1; tick(); idle(); done = 1; tick(); tick(); idle();

        // R3: retry raised by this master for a push does not force request off.
        req = 1; retry = 1; push = 1; tick();
        chk("R3 push keeps req", br, 1);
        idle(); cancel = 1; tick(); idle(); tick();

        // Random traffic compared against the model.
        for (int i = 0; i < 4000; i++) begin
            idle();
            req    = ($urandom_range(99) < 15);
            cancel = ($urandom_range(99) < 5);
            gnt    = ($urandom_range(99) < 50);
            busy_i = ($urandom_range(99) < 10);
            ts_i   = ($urandom_range(99) < 5);
            aack   = ($urandom_range(99) < ((m_own || m_other) ? 40 : 5));
            retry  = ($urandom_range(99) < 8);
            push   = ($urandom_range(99) < 30);
            done   = ($urandom_range(99) < 20);
            tick();
            model_cmp("R1-model R2-model R3-model R4-model R5-model R6-model R9-model");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog R10 actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

endmodule